// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer with a write port and a read port. Each port runs on its own clock, and the two clocks may be the same net or fully unrelated. Both data paths are 9 bits wide by default. Each port has an active-low enable. The read data comes out of a register and drives the output pins only while an active-low output enable is low.

The block reports four active-low status flags: empty, almost-empty, full and almost-full. The two "almost" thresholds sit in small registers. Software loads them, and reads them back, through the normal data ports while an active-low load strobe is held low. One internal selector per side steps through the pair, almost-empty threshold first. Pointers cross between the clock domains as Gray codes through a synchronizer chain, so each side's flags are conservative. A retransmit strobe on the read side rewinds the read pointer to storage location 0 so that the stored data can be read again.

Top module: `dcfifo_pflag`

## Requirements
- R1: Words leave on `q` in the order they were written, with all bits intact. A read loads the output register on the read-clock edge and does not wait for `oe_n`.
- R2: A write-clock edge stores `din` only when `wr_en_n` is low, `ld_n` is high and `full_n` is high. A write while full changes neither the stored data nor the count.
- R3: A read-clock edge removes a word only when `rd_en_n` is low, `ld_n` is high and `empty_n` is high. A read while empty leaves `q` and the flags unchanged.
- R4: With `ld_n` low, each enabled write edge loads `din[log2(DEPTH)-1:0]` into a threshold register, and storage is untouched. The first such write goes to the almost-empty threshold, the second to the almost-full threshold, and the order then repeats. Each enabled read edge with `ld_n` low puts one threshold on `q`, zero-extended, in the same alternating order, and removes no word.
- R5: After reset both thresholds are 7. `ae_n` is low when the read side sees at most the almost-empty threshold in words. `af_n` is low when the write side sees at most the almost-full threshold in free locations.
- R6: `empty_n` and `ae_n` are registers on `rclk`. A read affects them at the same edge. A write reaches them on the third read-clock edge after the write edge (SYNC_STAGES+1).
- R7: `full_n` and `af_n` are registers on `wclk`. A write affects them at the same edge. A read reaches them on the third write-clock edge after the read edge.
- R8: While `rst_n` is low, the buffer is empty, both selectors point at the almost-empty threshold, both thresholds are 7, `empty_n`=0, `ae_n`=0, `full_n`=1 and `af_n`=1. Reset must be applied before the first access.
- R9: With `oe_n` high, `q` is high impedance. With `oe_n` low, `q` drives the output register.
- R10: `retx_n` low at a read-clock edge sets the read pointer to location 0 and takes priority over any read on that edge. The write pointer does not move. The rewind replays correct data only while at most DEPTH words have been written since reset.
- R11: A write and a read on the same edge both take effect when the flags allow them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en_n | input | 1 | Active-low read enable |
| ld_n | input | 1 | Active-low strobe that redirects port accesses to the threshold registers |
| retx_n | input | 1 | Active-low retransmit, sampled on rclk |
| oe_n | input | 1 | Active-low output enable for q |
| din | input | WIDTH | Write data |
| q | output | WIDTH | Read data, high impedance while oe_n is high |
| empty_n | output | 1 | Low when empty (rclk) |
| ae_n | output | 1 | Low when almost empty (rclk) |
| full_n | output | 1 | Low when full (wclk) |
| af_n | output | 1 | Low when almost full (wclk) |

## Verification
A write and a read can fall on the same clock edge. The bench provokes this with long stretches in which both enables are low on every edge, and it also issues a retransmit on an edge that carries a write. The bench drives both ports from one clock net. A behavioural model with integer pointers, a word array and a three-deep history of each pointer predicts the output register and all four flags after every edge. The model treats a write as visible to the read side three edges late and a read as visible immediately, and the reverse on the write side. Each of these predictions is compared with the pins.

// File: rtl/fifo_pflag_pkg.sv
package fifo_pflag_pkg;
   // which threshold register an offset access targets
   typedef enum logic {SEL_EMPTY = 1'b0, SEL_FULL = 1'b1} thr_sel_e;

   function automatic logic [31:0] to_gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [31:0] from_gray(input logic [31:0] g);
      logic [31:0] b;
      b = g;
      for (int i = 1; i < 32; i++) b = b ^ (g >> i);
      return b;
   endfunction

   function automatic thr_sel_e next_sel(input thr_sel_e s);
      return (s == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
   endfunction
endpackage

// File: rtl/fifo_ptr_sync.sv
module fifo_ptr_sync #(
   parameter int W      = 7,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   if (STAGES < 2) begin : g_bad_stages
      $error("fifo_ptr_sync needs at least two stages");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
   parameter int WIDTH = 9,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             wclk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_wr_side.sv
module fifo_wr_side
   import fifo_pflag_pkg::*;
#(
   parameter int WIDTH      = 9,
   parameter int DEPTH      = 64,
   parameter int DEF_THRESH = 7,
   localparam int AW        = $clog2(DEPTH),
   localparam int PW        = AW + 1
) (
   input  logic             wclk,
   input  logic             rst_n,
   input  logic             wr_en_n,
   input  logic             ld_n,
   input  logic [WIDTH-1:0] din,
   input  logic [PW-1:0]    rgray_s,
   output logic [PW-1:0]    wbin,
   output logic [PW-1:0]    wgray,
   output logic             mem_we,
   output logic [AW-1:0]    waddr,
   output logic             full_n,
   output logic             af_n,
   output logic [AW-1:0]    ae_th,
   output logic [AW-1:0]    af_th
);
   localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

   thr_sel_e      wsel;
   logic          wr_fire, thr_wr;
   logic [PW-1:0] wbin_next, rbin_s, used, space;

   assign wr_fire   = !wr_en_n && ld_n && full_n;
   assign thr_wr    = !wr_en_n && !ld_n;
   assign wbin_next = wbin + PW'(wr_fire);
   assign rbin_s    = PW'(from_gray(32'(rgray_s)));
   assign used      = wbin_next - rbin_s;
   assign space     = DEPTH_P - used;
   assign mem_we    = wr_fire;
   assign waddr     = wbin[AW-1:0];

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wbin   <= '0;
         wgray  <= '0;
         full_n <= 1'b1;
         af_n   <= 1'b1;
         ae_th  <= AW'(DEF_THRESH);
         af_th  <= AW'(DEF_THRESH);
         wsel   <= SEL_EMPTY;
      end else begin
         wbin   <= wbin_next;
         wgray  <= PW'(to_gray(32'(wbin_next)));
         full_n <= (used != DEPTH_P);
         af_n   <= (space > {1'b0, af_th});
         if (thr_wr) begin
            if (wsel == SEL_EMPTY) ae_th <= din[AW-1:0];
            else                   af_th <= din[AW-1:0];
            wsel <= next_sel(wsel);
         end
      end
   end
endmodule

// File: rtl/fifo_rd_side.sv
module fifo_rd_side
   import fifo_pflag_pkg::*;
#(
   parameter int WIDTH = 9,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH),
   localparam int PW   = AW + 1
) (
   input  logic             rclk,
   input  logic             rst_n,
   input  logic             rd_en_n,
   input  logic             ld_n,
   input  logic             retx_n,
   input  logic [PW-1:0]    wgray_s,
   input  logic [AW-1:0]    ae_th,
   input  logic [AW-1:0]    af_th,
   input  logic [WIDTH-1:0] rdata,
   output logic [PW-1:0]    rbin,
   output logic [PW-1:0]    rgray,
   output logic [AW-1:0]    raddr,
   output logic             empty_n,
   output logic             ae_n,
   output logic [WIDTH-1:0] dout
);
   thr_sel_e         rsel;
   logic             rd_fire, thr_rd;
   logic [PW-1:0]    rbin_next, wbin_s, fill;
   logic [AW-1:0]    thr_pick;
   logic [WIDTH-1:0] thr_word;

   assign rd_fire   = !rd_en_n && ld_n && empty_n && retx_n;
   assign thr_rd    = !rd_en_n && !ld_n && retx_n;
   assign rbin_next = !retx_n ? '0 : rbin + PW'(rd_fire);
   assign wbin_s    = PW'(from_gray(32'(wgray_s)));
   assign fill      = wbin_s - rbin_next;
   assign raddr     = rbin[AW-1:0];
   assign thr_pick  = (rsel == SEL_EMPTY) ? ae_th : af_th;

   if (AW < WIDTH) begin : g_pad
      assign thr_word = {{(WIDTH-AW){1'b0}}, thr_pick};
   end else begin : g_nopad
      assign thr_word = thr_pick;
   end

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rbin    <= '0;
         rgray   <= '0;
         empty_n <= 1'b0;
         ae_n    <= 1'b0;
         dout    <= '0;
         rsel    <= SEL_EMPTY;
      end else begin
         rbin    <= rbin_next;
         rgray   <= PW'(to_gray(32'(rbin_next)));
         empty_n <= (fill != '0);
         ae_n    <= (fill > {1'b0, ae_th});
         if (rd_fire) begin
            dout <= rdata;
         end else if (thr_rd) begin
            dout <= thr_word;
            rsel <= next_sel(rsel);
         end
      end
   end
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
   parameter int WIDTH       = 9,
   parameter int DEPTH       = 64,
   parameter int SYNC_STAGES = 2,
   parameter int DEF_THRESH  = 7
) (
   input  logic             wclk,
   input  logic             rclk,
   input  logic             rst_n,
   input  logic             wr_en_n,
   input  logic             rd_en_n,
   input  logic             ld_n,
   input  logic             retx_n,
   input  logic             oe_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q,
   output logic             empty_n,
   output logic             ae_n,
   output logic             full_n,
   output logic             af_n
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (AW > WIDTH) begin : g_bad_width
      $error("thresholds must fit in the data width");
   end
   if (DEF_THRESH < 0 || DEF_THRESH >= DEPTH) begin : g_bad_thresh
      $error("DEF_THRESH must lie below DEPTH");
   end

   logic [PW-1:0]    wbin, rbin, wgray, rgray, wgray_s, rgray_s;
   logic [AW-1:0]    ae_th, af_th, waddr, raddr;
   logic             mem_we;
   logic [WIDTH-1:0] rdata, dout;

   fifo_wr_side #(.WIDTH(WIDTH), .DEPTH(DEPTH), .DEF_THRESH(DEF_THRESH)) u_wr (
      .wclk(wclk), .rst_n(rst_n), .wr_en_n(wr_en_n), .ld_n(ld_n), .din(din),
      .rgray_s(rgray_s), .wbin(wbin), .wgray(wgray), .mem_we(mem_we),
      .waddr(waddr), .full_n(full_n), .af_n(af_n), .ae_th(ae_th), .af_th(af_th));

   fifo_rd_side #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rd (
      .rclk(rclk), .rst_n(rst_n), .rd_en_n(rd_en_n), .ld_n(ld_n),
      .retx_n(retx_n), .wgray_s(wgray_s), .ae_th(ae_th), .af_th(af_th),
      .rdata(rdata), .rbin(rbin), .rgray(rgray), .raddr(raddr),
      .empty_n(empty_n), .ae_n(ae_n), .dout(dout));

   fifo_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));

   fifo_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

   fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
      .wclk(wclk), .we(mem_we), .waddr(waddr), .wdata(din),
      .raddr(raddr), .rdata(rdata));

   assign q = oe_n ? 'z : dout;
endmodule

// File: rtl/dcfifo_pflag_chk.sv
module dcfifo_pflag_chk #(
   parameter int PW = 7
) (
   input logic          wclk,
   input logic          rclk,
   input logic          rst_n,
   input logic          wr_en_n,
   input logic          rd_en_n,
   input logic          ld_n,
   input logic          retx_n,
   input logic          empty_n,
   input logic          ae_n,
   input logic          full_n,
   input logic          af_n,
   input logic [PW-1:0] wbin,
   input logic [PW-1:0] rbin
);
   AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
      (!full_n && !wr_en_n && ld_n) |=> $stable(wbin)); // R2

   AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n)
      (!empty_n && !rd_en_n && ld_n && retx_n) |=> $stable(rbin)); // R3

   AST_LOAD_NO_STORE: assert property (@(posedge wclk) disable iff (!rst_n)
      (!wr_en_n && !ld_n) |=> $stable(wbin)); // R4

   AST_WPTR_STEP: assert property (@(posedge wclk) disable iff (!rst_n)
      (wbin == $past(wbin)) || (wbin == PW'($past(wbin) + 1'b1))); // R2

   AST_FULL_IN_AF: assert property (@(posedge wclk) disable iff (!rst_n)
      !full_n |-> !af_n); // R5

   AST_EMPTY_IN_AE: assert property (@(posedge rclk) disable iff (!rst_n)
      !empty_n |-> !ae_n); // R5

   AST_RETX_REWIND: assert property (@(posedge rclk) disable iff (!rst_n)
      !retx_n |=> (rbin == '0)); // R10
endmodule

bind dcfifo_pflag dcfifo_pflag_chk #(.PW(PW)) u_chk (
   .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en_n(wr_en_n),
   .rd_en_n(rd_en_n), .ld_n(ld_n), .retx_n(retx_n), .empty_n(empty_n),
   .ae_n(ae_n), .full_n(full_n), .af_n(af_n), .wbin(wbin), .rbin(rbin));

// File: tb/sim_dcfifo_pflag.sv
`timescale 1ns/1ps
module sim_dcfifo_pflag;
   localparam int D  = 64;
   localparam int PW = 128;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en_n = 1'b1, rd_en_n = 1'b1, ld_n = 1'b1, retx_n = 1'b1, oe_n = 1'b0;
   logic [8:0] din = '0;
   tri1  [8:0] q;
   logic empty_n, ae_n, full_n, af_n;

   int checks = 0, fails = 0;
   bit done = 0;

   // behavioural reference state
   int wp, rp, aoff, foff;
   int wh[4], rh[4];
   int mm[D];
   int dq;
   bit wsel, rsel, e_x, ae_x, f_x, af_x;

   always #4 clk = ~clk;

   dcfifo_pflag u0 (
      .wclk(clk), .rclk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n),
      .rd_en_n(rd_en_n), .ld_n(ld_n), .retx_n(retx_n), .oe_n(oe_n),
      .din(din), .q(q), .empty_n(empty_n), .ae_n(ae_n),
      .full_n(full_n), .af_n(af_n));

   task automatic check(input string tag, input string sig, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, sig, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      wp = 0; rp = 0; aoff = 7; foff = 7; dq = 0;
      for (int i = 0; i < 4; i++) begin wh[i] = 0; rh[i] = 0; end
      wsel = 0; rsel = 0; e_x = 0; ae_x = 0; f_x = 1; af_x = 1;
   endtask

   task automatic model_edge(input logic we, re, l, rt, input logic [8:0] d);
      int old_a, old_f, fill, used;
      bit old_e, old_full;
      old_a = aoff; old_f = foff; old_e = e_x; old_full = f_x;
      if (!rt) rp = 0;
      else if (!re) begin
         if (!l) begin dq = rsel ? foff : aoff; rsel = !rsel; end
         else if (old_e) begin dq = mm[rp % D]; rp = (rp + 1) % PW; end
      end
      if (!we) begin
         if (!l) begin
            if (!wsel) aoff = int'(d[5:0]); else foff = int'(d[5:0]);
            wsel = !wsel;
         end else if (old_full) begin
            mm[wp % D] = int'(d); wp = (wp + 1) % PW;
         end
      end
      for (int i = 3; i > 0; i--) begin wh[i] = wh[i-1]; rh[i] = rh[i-1]; end
      wh[0] = wp; rh[0] = rp;
      fill = (wh[3] - rp + PW) % PW;
      e_x  = (fill != 0);
      ae_x = (fill > old_a);
      used = (wp - rh[3] + PW) % PW;
      f_x  = (used != D);
      af_x = ((D - used) > old_f);
   endtask

   task automatic compare(input string tag);
      check(oe_n ? "R9" : tag, "q", int'(q), oe_n ? 511 : dq);
      check("R6", "empty_n", int'(empty_n), int'(e_x));
      check("R6", "ae_n", int'(ae_n), int'(ae_x));
      check("R7", "full_n", int'(full_n), int'(f_x));
      check("R7", "af_n", int'(af_n), int'(af_x));
   endtask

   // called at a falling edge; applies inputs over one rising edge
   task automatic step(input logic we, re, l, rt, input logic [8:0] d, input string tag);
      wr_en_n = we; rd_en_n = re; ld_n = l; retx_n = rt; din = d;
      @(posedge clk);
      @(negedge clk);
      model_edge(we, re, l, rt, d);
      compare(tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1, 1, 1, 1, 9'h0, tag);
   endtask

   task automatic do_reset();
      wr_en_n = 1; rd_en_n = 1; ld_n = 1; retx_n = 1;
      rst_n = 0;
      @(negedge clk); @(negedge clk);
      model_reset();
      compare("R8");
      rst_n = 1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #(8 * 100000);
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      model_reset();
      @(negedge clk);
      do_reset();
      idle(3, "R8");
      check("R8", "reset empty_n", int'(empty_n), 0);
      check("R8", "reset full_n", int'(full_n), 1);

      // R1: ordering with gaps and flag transitions at default thresholds (R5)
      for (int i = 0; i < 10; i++) begin step(0, 1, 1, 1, 9'(9'h1A0 + i), "R1"); idle(1, "R5"); end
      idle(4, "R5");
      for (int i = 0; i < 10; i++) step(1, 0, 1, 1, 9'h0, "R1");
      idle(4, "R6");

      // R2: overfill; 64 stored, the rest ignored
      for (int i = 0; i < 70; i++) step(0, 1, 1, 1, 9'(i * 7 + 3), "R2");
      idle(4, "R7");
      check("R2", "full_n after overfill", int'(full_n), 0);
      // R3: drain plus reads on empty
      for (int i = 0; i < 66; i++) step(1, 0, 1, 1, 9'h0, "R3");
      check("R3", "q held after empty reads", int'(q), (63 * 7 + 3) % 512);
      idle(4, "R3");

      // R4: load thresholds then read them back
      step(0, 1, 0, 1, 9'd3, "R4");
      step(0, 1, 0, 1, 9'd10, "R4");
      idle(2, "R4");
      step(1, 0, 0, 1, 9'h0, "R4");
      check("R4", "almost-empty threshold readback", int'(q), 3);
      step(1, 0, 0, 1, 9'h0, "R4");
      check("R4", "almost-full threshold readback", int'(q), 10);
      step(1, 0, 0, 1, 9'h0, "R4");
      check("R4", "selector wraps", int'(q), 3);
      idle(3, "R4");
      check("R4", "no word stored by loads", int'(empty_n), 0);

      // R5/R6/R7: reprogrammed thresholds across a fill and drain
      for (int i = 0; i < 60; i++) step(0, 1, 1, 1, 9'(9'h055 + i), "R5");
      idle(4, "R7");
      check("R5", "af_n with 4 free and threshold 10", int'(af_n), 0);
      for (int i = 0; i < 60; i++) step(1, 0, 1, 1, 9'h0, "R6");
      idle(4, "R6");

      // R11: simultaneous write and read on the same edges
      for (int i = 0; i < 5; i++) step(0, 1, 1, 1, 9'(9'h0F0 + i), "R11");
      for (int i = 0; i < 30; i++) step(0, 0, 1, 1, 9'(9'h140 + i), "R11");
      for (int i = 0; i < 12; i++) step(1, 0, 1, 1, 9'h0, "R11");
      idle(4, "R11");

      // R9: output enable
      oe_n = 1; idle(3, "R9");
      oe_n = 0; idle(1, "R9");

      // R10: retransmit coinciding with a write
      do_reset();
      for (int i = 0; i < 6; i++) step(0, 1, 1, 1, 9'(9'h0C1 + i), "R10");
      idle(4, "R10");
      for (int i = 0; i < 4; i++) step(1, 0, 1, 1, 9'h0, "R10");
      step(0, 0, 1, 0, 9'h0CF, "R10");
      idle(4, "R10");
      step(1, 0, 1, 1, 9'h0, "R10");
      check("R10", "first word replayed", int'(q), 9'h0C1);
      for (int i = 0; i < 7; i++) step(1, 0, 1, 1, 9'h0, "R10");
      idle(4, "R10");

      finish_run();
   end
endmodule